// File: doc/BRIEF.md
# Dual 16-Pin GPIO Port with Level Resolution and Change Notification

The block provides two general-purpose ports, A and B, of 16 pins each, controlled over a simple single-cycle register bus. Each port has a 32-bit control word, which sets the output drive and the pull-up for every pin, and a 16-bit data word. Each pin's visible level is a wired-OR of three sources: the level the CPU drives, the level the attached peripherals drive (a direction and a data vector per port, given as inputs), and the pull-up. The pull-up only has an effect when neither the CPU nor a peripheral drives the pin.

Software reading a data address sees the resolved pin levels, not the stored value. On every write to a port's control or data word, the block compares the resolved level before and after the write. It raises a one-cycle strobe toward each of up to four peripheral slots whose trigger mask covers a pin that changed. Along with the strobes it presents a snapshot of the resolved levels of both ports. A write of a nonzero value to the pin-interrupt control word is unsupported, and it raises a sticky error flag.

Top module: `gpio_pair`

## Requirements
- R1: In a port control word, bit 2n enables the CPU drive of pin n and bit 2n+1 enables its pull-up, for n = 0..15.
- R2: Each resolved pin = (cpu_oe AND cpu_data) OR (per_oe AND per_data) OR (NOT(cpu_oe OR per_oe) AND pullup). This level appears on pins_a_o / pins_b_o.
- R3: Register addresses are 0 = control A, 1 = data A, 2 = control B, 3 = data B, 4 = pin-interrupt control, and any other address reads 0. A control address reads back the stored word. A data address reads the resolved pins in bits 15:0, with zeros above. Address 4 reads back its stored bits 15:0.
- R4: A write to addresses 0..3 that changes the resolved level of the written port produces notify strobes in the cycle after the write, lasting exactly one cycle. A write that changes no resolved pin produces no strobe.
- R5: Slot i is strobed only if slot_valid_i[i] is 1 and its trigger mask for the written port overlaps the changed pins. Slot i's masks occupy bits [16i+15:16i] of slot_mask_a_i / slot_mask_b_i.
- R6: While any strobe is high, notify_lvl_a_o and notify_lvl_b_o hold the resolved levels of both ports just after the write, including the port that was not written.
- R7: A change on the peripheral direction or data inputs alone, with no register write, raises no strobe.
- R8: Writing a nonzero bits 15:0 to address 4 sets pirq_err_o, which stays set until reset. Writing zero leaves it clear.
- R9: After reset, all registers are zero, no strobe is high and pirq_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational on addr_i) |
| per_oe_a_i | input | 16 | Peripheral drive enables, port A |
| per_dat_a_i | input | 16 | Peripheral drive levels, port A |
| per_oe_b_i | input | 16 | Peripheral drive enables, port B |
| per_dat_b_i | input | 16 | Peripheral drive levels, port B |
| slot_valid_i | input | 4 | Slot registered flags |
| slot_mask_a_i | input | 64 | Per-slot trigger masks, port A |
| slot_mask_b_i | input | 64 | Per-slot trigger masks, port B |
| notify_o | output | 4 | Per-slot change strobes |
| notify_lvl_a_o | output | 16 | Port A level snapshot with strobes |
| notify_lvl_b_o | output | 16 | Port B level snapshot with strobes |
| pins_a_o | output | 16 | Resolved port A levels |
| pins_b_o | output | 16 | Resolved port B levels |
| pirq_err_o | output | 1 | Sticky unsupported-write error |

## Verification
The notification logic computes its before and after levels from the peripheral inputs and slot settings as they stand in the write cycle. The strobe checks therefore take for granted that these inputs do not move in the same cycle as a register write. The stimulus changes the peripheral inputs and the slot settings only in idle cycles. It then waits one more idle cycle before the next write, and checks at that point that the peripheral change on its own raised no strobe. The per-pin sweep rotates all 32 combinations of CPU drive, CPU data, peripheral drive, peripheral data and pull-up across the pins of both ports.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL_A = 3'd0,
    SEL_DATA_A = 3'd1,
    SEL_CTRL_B = 3'd2,
    SEL_DATA_B = 3'd3,
    SEL_PIRQ   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_ctrl_split.sv
module gpio_ctrl_split #(
  parameter int NPINS = 16,
  localparam int CW = 2 * NPINS
) (
  input  logic [CW-1:0]    ctrl_i,
  output logic [NPINS-1:0] oe_o,
  output logic [NPINS-1:0] pu_o
);
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    assign oe_o[gi] = ctrl_i[2*gi];
    assign pu_o[gi] = ctrl_i[2*gi+1];
  end
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve #(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0] cpu_oe_i,
  input  logic [NPINS-1:0] cpu_dat_i,
  input  logic [NPINS-1:0] per_oe_i,
  input  logic [NPINS-1:0] per_dat_i,
  input  logic [NPINS-1:0] pu_i,
  output logic [NPINS-1:0] lvl_o
);
  assign lvl_o = (cpu_oe_i & cpu_dat_i) | (per_oe_i & per_dat_i) |
                 (~(cpu_oe_i | per_oe_i) & pu_i);
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPINS = 16,
  localparam int CW = 2 * NPINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_data_i,
  input  logic [CW-1:0]    wdata_i,
  input  logic [NPINS-1:0] per_oe_i,
  input  logic [NPINS-1:0] per_dat_i,
  output logic [CW-1:0]    ctrl_o,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] lvl_next_o
);
  logic [CW-1:0]    ctrl_q, ctrl_d;
  logic [NPINS-1:0] dat_q, dat_d;
  logic [NPINS-1:0] oe_q, pu_q, oe_d, pu_d;

  assign ctrl_d = wr_ctrl_i ? wdata_i : ctrl_q;
  assign dat_d  = wr_data_i ? wdata_i[NPINS-1:0] : dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dat_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dat_q  <= dat_d;
    end
  end

  // current view and post-write view, resolved side by side
  gpio_ctrl_split #(.NPINS(NPINS)) u_split_q (.ctrl_i(ctrl_q), .oe_o(oe_q), .pu_o(pu_q));
  gpio_ctrl_split #(.NPINS(NPINS)) u_split_d (.ctrl_i(ctrl_d), .oe_o(oe_d), .pu_o(pu_d));

  gpio_pin_resolve #(.NPINS(NPINS)) u_res_q (
    .cpu_oe_i(oe_q), .cpu_dat_i(dat_q), .per_oe_i(per_oe_i),
    .per_dat_i(per_dat_i), .pu_i(pu_q), .lvl_o(lvl_o));
  gpio_pin_resolve #(.NPINS(NPINS)) u_res_d (
    .cpu_oe_i(oe_d), .cpu_dat_i(dat_d), .per_oe_i(per_oe_i),
    .per_dat_i(per_dat_i), .pu_i(pu_d), .lvl_o(lvl_next_o));

  assign ctrl_o = ctrl_q;

  AST_IDLE_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ctrl_i || wr_data_i) |-> lvl_next_o == lvl_o) // R7
    else $error("port level moved without a write");
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify #(
  parameter int NPINS  = 16,
  parameter int NSLOTS = 4,
  localparam int MW = NPINS * NSLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  chg_a_i,
  input  logic [NPINS-1:0]  chg_b_i,
  input  logic [NSLOTS-1:0] slot_valid_i,
  input  logic [MW-1:0]     slot_mask_a_i,
  input  logic [MW-1:0]     slot_mask_b_i,
  output logic [NSLOTS-1:0] notify_o
);
  logic [NSLOTS-1:0] hit;

  for (genvar gi = 0; gi < NSLOTS; gi++) begin : g_slot
    assign hit[gi] = slot_valid_i[gi] &&
      (|((slot_mask_a_i[gi*NPINS +: NPINS] & chg_a_i) |
         (slot_mask_b_i[gi*NPINS +: NPINS] & chg_b_i)));

    AST_SLOT_REGISTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      notify_o[gi] |-> $past(slot_valid_i[gi])) // R5
      else $error("strobe to unregistered slot");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) notify_o <= '0;
    else         notify_o <= hit;
  end
endmodule

// File: rtl/gpio_pair.sv
module gpio_pair
  import gpio_pair_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int NSLOTS = 4,
  localparam int CW = 2 * NPINS,
  localparam int MW = NPINS * NSLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  input  logic [NPINS-1:0]  per_oe_a_i,
  input  logic [NPINS-1:0]  per_dat_a_i,
  input  logic [NPINS-1:0]  per_oe_b_i,
  input  logic [NPINS-1:0]  per_dat_b_i,
  input  logic [NSLOTS-1:0] slot_valid_i,
  input  logic [MW-1:0]     slot_mask_a_i,
  input  logic [MW-1:0]     slot_mask_b_i,
  output logic [NSLOTS-1:0] notify_o,
  output logic [NPINS-1:0]  notify_lvl_a_o,
  output logic [NPINS-1:0]  notify_lvl_b_o,
  output logic [NPINS-1:0]  pins_a_o,
  output logic [NPINS-1:0]  pins_b_o,
  output logic              pirq_err_o
);
  reg_sel_e         sel;
  logic             wr_ca, wr_da, wr_cb, wr_db, wr_pirq, wr_port;
  logic [CW-1:0]    ctrl_a, ctrl_b;
  logic [NPINS-1:0] nxt_a, nxt_b;
  logic [NPINS-1:0] pirq_q;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_ca   = wr_en_i && (sel == SEL_CTRL_A);
  assign wr_da   = wr_en_i && (sel == SEL_DATA_A);
  assign wr_cb   = wr_en_i && (sel == SEL_CTRL_B);
  assign wr_db   = wr_en_i && (sel == SEL_DATA_B);
  assign wr_pirq = wr_en_i && (sel == SEL_PIRQ);
  assign wr_port = wr_ca | wr_da | wr_cb | wr_db;

  gpio_port #(.NPINS(NPINS)) u_port_a (
    .clk_i, .rst_ni, .wr_ctrl_i(wr_ca), .wr_data_i(wr_da), .wdata_i,
    .per_oe_i(per_oe_a_i), .per_dat_i(per_dat_a_i),
    .ctrl_o(ctrl_a), .lvl_o(pins_a_o), .lvl_next_o(nxt_a));

  gpio_port #(.NPINS(NPINS)) u_port_b (
    .clk_i, .rst_ni, .wr_ctrl_i(wr_cb), .wr_data_i(wr_db), .wdata_i,
    .per_oe_i(per_oe_b_i), .per_dat_i(per_dat_b_i),
    .ctrl_o(ctrl_b), .lvl_o(pins_b_o), .lvl_next_o(nxt_b));

  gpio_notify #(.NPINS(NPINS), .NSLOTS(NSLOTS)) u_notify (
    .clk_i, .rst_ni,
    .chg_a_i(nxt_a ^ pins_a_o), .chg_b_i(nxt_b ^ pins_b_o),
    .slot_valid_i, .slot_mask_a_i, .slot_mask_b_i, .notify_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      notify_lvl_a_o <= '0;
      notify_lvl_b_o <= '0;
      pirq_q         <= '0;
      pirq_err_o     <= 1'b0;
    end else begin
      if (wr_port) begin
        notify_lvl_a_o <= nxt_a;
        notify_lvl_b_o <= nxt_b;
      end
      if (wr_pirq) begin
        pirq_q <= wdata_i[NPINS-1:0];
        if (|wdata_i[NPINS-1:0]) pirq_err_o <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CTRL_A: rdata_o = ctrl_a;
      SEL_DATA_A: rdata_o[NPINS-1:0] = pins_a_o;
      SEL_CTRL_B: rdata_o = ctrl_b;
      SEL_DATA_B: rdata_o[NPINS-1:0] = pins_b_o;
      SEL_PIRQ:   rdata_o[NPINS-1:0] = pirq_q;
      default:    rdata_o = '0;
    endcase
  end

  AST_STROBE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|notify_o) |-> $past(wr_port)) // R4
    else $error("strobe without preceding port write");

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pirq_err_o |=> pirq_err_o) // R8
    else $error("error flag cleared");

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pirq_err_o) |-> $past(wr_pirq && (|wdata_i[NPINS-1:0]))) // R8
    else $error("error flag set without nonzero write");
endmodule

// File: tb/gpio_pair_test.sv
module gpio_pair_test;
  localparam int N = 16;
  localparam int S = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [2:0]    addr = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata;
  logic [N-1:0]  poa = 0, pda = 0, pob = 0, pdb = 0;
  logic [S-1:0]  sval;
  logic [N*S-1:0] ma, mb;
  logic [S-1:0]  notify;
  logic [N-1:0]  nla, nlb, pins_a, pins_b;
  logic          err;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [31:0] m_ca = 0, m_cb = 0;
  logic [15:0] m_da = 0, m_db = 0;

  always #2.5 clk = ~clk;

  gpio_pair uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .per_oe_a_i(poa), .per_dat_a_i(pda), .per_oe_b_i(pob),
    .per_dat_b_i(pdb), .slot_valid_i(sval), .slot_mask_a_i(ma), .slot_mask_b_i(mb),
    .notify_o(notify), .notify_lvl_a_o(nla), .notify_lvl_b_o(nlb),
    .pins_a_o(pins_a), .pins_b_o(pins_b), .pirq_err_o(err));

  function automatic logic [15:0] resolve(input logic [31:0] c, input logic [15:0] d,
                                          input logic [15:0] po, input logic [15:0] pd);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) begin
      logic oe, pu;
      oe = c[2*n];
      pu = c[2*n+1];
      r[n] = (oe & d[n]) | (po[n] & pd[n]) | (~(oe | po[n]) & pu);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  // write, then check strobes (R4/R5) and snapshot (R6), then one-cycle width
  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    logic [15:0] ba, bb, aa, ab, ca, cb;
    logic [S-1:0] exp_n;
    ba = resolve(m_ca, m_da, poa, pda);
    bb = resolve(m_cb, m_db, pob, pdb);
    case (a)
      3'd0: m_ca = v;
      3'd1: m_da = v[15:0];
      3'd2: m_cb = v;
      3'd3: m_db = v[15:0];
      default: ;
    endcase
    aa = resolve(m_ca, m_da, poa, pda);
    ab = resolve(m_cb, m_db, pob, pdb);
    ca = aa ^ ba;
    cb = ab ^ bb;
    for (int i = 0; i < S; i++)
      exp_n[i] = sval[i] && (((ma[i*N +: N] & ca) | (mb[i*N +: N] & cb)) != 0);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 0;
    if (a <= 3'd3) begin
      chk("R4/R5 strobes after write", notify, exp_n);
      if (exp_n != 0) begin
        chk("R6 snapshot A", nla, aa);
        chk("R6 snapshot B", nlb, ab);
      end
      @(negedge clk);
      chk("R4 strobe single cycle", notify, 0);
    end
  endtask

  logic [31:0] v;
  initial begin
    sval = 4'b0111;
    ma = {16'hFFFF, 16'h0000, 16'hFF00, 16'h00FF};
    mb = {16'hFFFF, 16'hFFFF, 16'h00F0, 16'h0000};
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 notify", notify, 0);
    chk("R9 err", err, 0);
    chk("R9 pins A", pins_a, 0);
    chk("R9 pins B", pins_b, 0);
    rst_n = 1;
    rd(3'd0, v); chk("R9 ctrl A", v, 0);
    rd(3'd2, v); chk("R9 ctrl B", v, 0);

    // R1/R2 sweep: every pin cycles through all 32 source combinations
    for (int k = 0; k < 32; k++) begin
      logic [31:0] ca_w, cb_w;
      logic [15:0] da_w, db_w, npoa, npda, npob, npdb;
      for (int n = 0; n < 16; n++) begin
        int va, vb;
        va = (n * 7 + k) % 32;
        vb = (n * 3 + k + 5) % 32;
        ca_w[2*n] = va[0]; da_w[n] = va[1]; npoa[n] = va[2]; npda[n] = va[3]; ca_w[2*n+1] = va[4];
        cb_w[2*n] = vb[0]; db_w[n] = vb[1]; npob[n] = vb[2]; npdb[n] = vb[3]; cb_w[2*n+1] = vb[4];
      end
      @(negedge clk);
      poa = npoa; pda = npda; pob = npob; pdb = npdb;
      @(negedge clk);
      chk("R7 no strobe on peripheral change", notify, 0);
      @(negedge clk);
      chk("R7 still no strobe", notify, 0);
      wr(3'd0, ca_w);
      wr(3'd1, {16'hDEAD, da_w});
      wr(3'd2, cb_w);
      wr(3'd3, {16'h0, db_w});
      rd(3'd1, v); chk("R3/R2 data A reads resolved", v, {16'h0, resolve(m_ca, m_da, poa, pda)});
      rd(3'd3, v); chk("R3/R2 data B reads resolved", v, {16'h0, resolve(m_cb, m_db, pob, pdb)});
      rd(3'd0, v); chk("R3/R1 ctrl A readback", v, m_ca);
      rd(3'd2, v); chk("R3/R1 ctrl B readback", v, m_cb);
      chk("R2 pins A", pins_a, resolve(m_ca, m_da, poa, pda));
      chk("R2 pins B", pins_b, resolve(m_cb, m_db, pob, pdb));
    end

    // directed: no peripheral drive, CPU outputs only
    @(negedge clk);
    poa = 0; pda = 0; pob = 0; pdb = 0;
    wr(3'd0, 32'h5555_5555);   // R1 all outputs enabled, no pull-ups
    wr(3'd1, 32'h0000_0000);
    wr(3'd1, 32'h0000_0000);   // R4 repeated value: no change, no strobe
    chk("R4 no-change write", notify, 0);
    wr(3'd1, 32'h0000_8001);   // R5 slot0 (bit0) and slot1 (bit15) hit; slot3 unregistered
    wr(3'd2, 32'hAAAA_AAAA);   // R1 pull-ups only on B: all high, slots 1,2 via B
    chk("R2 pull-ups B", pins_b, 16'hFFFF);
    wr(3'd0, 32'h0000_0000);   // A drive off: pins A fall to 0
    chk("R6 A write shows B", nlb, 16'hFFFF);
    rd(3'd5, v); chk("R3 unmapped reads 0", v, 0);

    // R8 error flag
    wr(3'd4, 32'hFFFF_0000);
    chk("R8 zero low half no error", err, 0);
    rd(3'd4, v); chk("R3 pirq readback", v, 0);
    wr(3'd4, 32'h0000_0010);
    chk("R8 nonzero sets error", err, 1);
    wr(3'd4, 32'h0);
    @(negedge clk);
    chk("R8 error sticky", err, 1);
    chk("R8 no strobe from pirq write", notify, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule